// File: doc/BRIEF.md
# Trap Entry Controller

This block carries out the architectural state change that happens when a hart takes a trap. A trap request comes in with a flag saying whether it is an interrupt or an exception, a cause code, the program counter of the interrupted instruction, the privilege level the hart is running at, the faulting address and the transformed instruction word. The block chooses which privilege level handles the trap, then loads the matching exception-PC, trap-value and trap-instruction registers. It also computes the handler address from that level's trap-vector register and switches the privilege level.

The delegation registers and the two trap-vector registers come in as plain inputs from the CSR file, which lies outside this block. The registers the block updates go out as outputs. It has a small two-state machine. `ST_IDLE` means no redirect is pending. `ST_REDIRECT` lasts for the one cycle after a trap is accepted and drives the `redirect_o` pulse, which tells fetch to load `pc_o`. A trap request moves the machine to `ST_REDIRECT` from either state. A cycle with no request moves it back to `ST_IDLE`. All register updates happen on the clock edge that samples the request.

Privilege encoding: 0 is user (U), 1 is supervisor (S), 3 is machine (M).

Top module: `trap_entry_ctrl`

## Requirements
- R1: While `rst_n` is low, every exception-PC, trap-value and trap-instruction output is 0, `pc_o` equals `RESET_PC`, `priv_o` is 3 (M), `redirect_o` is 0 and the state is `ST_IDLE`.
- R2: A trap taken from U (0) or S (1) is routed to S only when the selected delegation bit is set. For an interrupt that bit is `mideleg_i[cause]`; for an exception it is `medeleg_i[cause]`. Otherwise the trap is routed to M.
- R3: A trap taken while `cur_priv_i` is 3 (M) always goes to M, whatever the delegation bits hold.
- R4: A trap routed to S loads `sepc_o` with `cur_pc_i` and loads `stval_o` and `stinst_o`. It sets `priv_o` to 1 and leaves `mepc_o`, `mtval_o` and `mtinst_o` unchanged.
- R5: A trap routed to M loads `mepc_o` with `cur_pc_i` and loads `mtval_o` and `mtinst_o`. It sets `priv_o` to 3 and leaves `sepc_o`, `stval_o` and `stinst_o` unchanged.
- R6: For the data-access exception causes 4, 5, 6, 7, 13, 15, 21 and 23, the trap value is `fault_addr_i` and the trap instruction is `xinst_i`.
- R7: For the instruction-fetch exception causes 0, 1, 12 and 20, the trap value is `fault_addr_i` and the trap instruction is 0.
- R8: For every other exception cause and for every interrupt, both the trap value and the trap instruction are 0.
- R9: The handler address in `pc_o` is the selected trap-vector register with bits [1:0] forced to 0. This holds for every exception and for interrupts when the vector mode is not 1.
- R10: When the trap is an interrupt and bits [1:0] of the selected trap-vector register equal 1, `pc_o` is the cleared base plus cause×4. An exception under the same vector setting gets no offset.
- R11: `redirect_o` is 1 exactly in the cycle after a trap request is sampled. In a cycle with `trap_req_i` low, the next edge leaves every output register and `priv_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trap_req_i | input | 1 | Take a trap on this edge |
| trap_is_irq_i | input | 1 | 1 = interrupt, 0 = exception |
| trap_cause_i | input | CAUSE_W | Cause code |
| cur_pc_i | input | XLEN | PC of the trapping instruction |
| cur_priv_i | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| fault_addr_i | input | XLEN | Faulting address |
| xinst_i | input | XLEN | Transformed instruction word |
| mideleg_i | input | XLEN | Interrupt delegation bits |
| medeleg_i | input | XLEN | Exception delegation bits |
| mtvec_i | input | XLEN | Machine trap-vector register |
| stvec_i | input | XLEN | Supervisor trap-vector register |
| sepc_o | output | XLEN | Supervisor exception PC |
| stval_o | output | XLEN | Supervisor trap value |
| stinst_o | output | XLEN | Supervisor-level trap instruction |
| mepc_o | output | XLEN | Machine exception PC |
| mtval_o | output | XLEN | Machine trap value |
| mtinst_o | output | XLEN | Machine trap instruction |
| pc_o | output | XLEN | Handler address |
| priv_o | output | 2 | Privilege after the trap |
| redirect_o | output | 1 | One-cycle pulse: fetch from `pc_o` |

## Verification
The assertions check on every cycle the following properties:
- the redirect pulse follows each request and is absent otherwise;
- M-level traps never leave M;
- the register file holds when no trap is requested;
- the handler address stays word aligned;
- interrupts clear the trap value and trap instruction of the level they reach;
- a delegated exception from U or S lands in S with the sampled PC.

Only the bench scenarios can show the exact trap-value and trap-instruction choice per cause class and the vectored offset of cause×4. They also show that the interrupt and exception delegation registers are consulted separately, using directed traps whose delegation bits are set in one register and clear in the other.

// File: rtl/trap_pkg.sv
package trap_pkg;

    // Privilege encodings
    localparam logic [1:0] PRIV_U = 2'b00;
    localparam logic [1:0] PRIV_S = 2'b01;
    localparam logic [1:0] PRIV_M = 2'b11;

    // Vector mode value that enables the interrupt offset
    localparam logic [1:0] VEC_MODE_SPREAD = 2'b01;

    // Controller states
    typedef enum logic [0:0] {
        ST_IDLE     = 1'b0,
        ST_REDIRECT = 1'b1
    } fsm_e;

    // What the trap-value / trap-instruction pair carries
    typedef enum logic [1:0] {
        INFO_NONE  = 2'd0,
        INFO_FETCH = 2'd1,
        INFO_DATA  = 2'd2
    } info_e;

    // Sort an exception cause into its reporting class
    function automatic info_e classify(input logic is_irq, input logic [7:0] code);
        info_e cls;
        cls = INFO_NONE;
        if (!is_irq) begin
            unique case (code)
                8'd4, 8'd5, 8'd6, 8'd7,
                8'd13, 8'd15, 8'd21, 8'd23: cls = INFO_DATA;
                8'd0, 8'd1, 8'd12, 8'd20:   cls = INFO_FETCH;
                default:                    cls = INFO_NONE;
            endcase
        end
        return cls;
    endfunction

endpackage

// File: rtl/trap_route.sv
module trap_route #(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = $clog2(XLEN)
) (
    input  logic               is_irq,
    input  logic [CAUSE_W-1:0] cause,
    input  logic [1:0]         cur_priv,
    input  logic [XLEN-1:0]    irq_deleg,
    input  logic [XLEN-1:0]    exc_deleg,
    output logic               to_super
);
    import trap_pkg::*;

    logic from_low;
    logic bit_set;

    always_comb begin
        from_low = (cur_priv == PRIV_U) || (cur_priv == PRIV_S);
        bit_set  = is_irq ? irq_deleg[cause] : exc_deleg[cause];
        to_super = from_low && bit_set;
    end
endmodule

// File: rtl/trap_info.sv
module trap_info #(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = $clog2(XLEN)
) (
    input  logic               is_irq,
    input  logic [CAUSE_W-1:0] cause,
    input  logic [XLEN-1:0]    fault_addr,
    input  logic [XLEN-1:0]    xinst,
    output logic [XLEN-1:0]    tval,
    output logic [XLEN-1:0]    tinst
);
    import trap_pkg::*;

    info_e cls;

    always_comb begin
        cls = classify(is_irq, 8'(cause));
        unique case (cls)
            INFO_DATA: begin
                tval  = fault_addr;
                tinst = xinst;
            end
            INFO_FETCH: begin
                tval  = fault_addr;
                tinst = '0;
            end
            default: begin
                tval  = '0;
                tinst = '0;
            end
        endcase
    end
endmodule

// File: rtl/trap_vector.sv
module trap_vector #(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = $clog2(XLEN)
) (
    input  logic               is_irq,
    input  logic [CAUSE_W-1:0] cause,
    input  logic [XLEN-1:0]    tvec,
    output logic [XLEN-1:0]    target
);
    import trap_pkg::*;

    localparam int PAD_W = XLEN - CAUSE_W - 2;

    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offset;

    always_comb begin
        base = {tvec[XLEN-1:2], 2'b00};
        if (is_irq && (tvec[1:0] == VEC_MODE_SPREAD)) begin
            offset = {{PAD_W{1'b0}}, cause, 2'b00};
        end else begin
            offset = '0;
        end
        target = base + offset;
    end
endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl #(
    parameter int          XLEN     = 32,
    parameter logic [31:0] RESET_PC = 32'h0000_0000,
    parameter int          CAUSE_W  = $clog2(XLEN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trap_req_i,
    input  logic               trap_is_irq_i,
    input  logic [CAUSE_W-1:0] trap_cause_i,
    input  logic [XLEN-1:0]    cur_pc_i,
    input  logic [1:0]         cur_priv_i,
    input  logic [XLEN-1:0]    fault_addr_i,
    input  logic [XLEN-1:0]    xinst_i,
    input  logic [XLEN-1:0]    mideleg_i,
    input  logic [XLEN-1:0]    medeleg_i,
    input  logic [XLEN-1:0]    mtvec_i,
    input  logic [XLEN-1:0]    stvec_i,
    output logic [XLEN-1:0]    sepc_o,
    output logic [XLEN-1:0]    stval_o,
    output logic [XLEN-1:0]    stinst_o,
    output logic [XLEN-1:0]    mepc_o,
    output logic [XLEN-1:0]    mtval_o,
    output logic [XLEN-1:0]    mtinst_o,
    output logic [XLEN-1:0]    pc_o,
    output logic [1:0]         priv_o,
    output logic               redirect_o
);
    import trap_pkg::*;

    localparam logic [XLEN-1:0] PC_AT_RESET = XLEN'(RESET_PC);

    fsm_e            state_q, state_d;
    logic            to_super;
    logic [XLEN-1:0] tval_w, tinst_w, sel_tvec, target_w;

    trap_route #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_route (
        .is_irq    (trap_is_irq_i),
        .cause     (trap_cause_i),
        .cur_priv  (cur_priv_i),
        .irq_deleg (mideleg_i),
        .exc_deleg (medeleg_i),
        .to_super  (to_super)
    );

    trap_info #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_info (
        .is_irq     (trap_is_irq_i),
        .cause      (trap_cause_i),
        .fault_addr (fault_addr_i),
        .xinst      (xinst_i),
        .tval       (tval_w),
        .tinst      (tinst_w)
    );

    always_comb sel_tvec = to_super ? stvec_i : mtvec_i;

    trap_vector #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_vec (
        .is_irq (trap_is_irq_i),
        .cause  (trap_cause_i),
        .tvec   (sel_tvec),
        .target (target_w)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     state_d = trap_req_i ? ST_REDIRECT : ST_IDLE;
            ST_REDIRECT: state_d = trap_req_i ? ST_REDIRECT : ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            ST_REDIRECT: redirect_o = 1'b1;
            default:     redirect_o = 1'b0;
        endcase
    end

    // Trap register file
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sepc_o   <= '0;
            stval_o  <= '0;
            stinst_o <= '0;
            mepc_o   <= '0;
            mtval_o  <= '0;
            mtinst_o <= '0;
            pc_o     <= PC_AT_RESET;
            priv_o   <= PRIV_M;
        end else if (trap_req_i) begin
            pc_o <= target_w;
            if (to_super) begin
                sepc_o   <= cur_pc_i;
                stval_o  <= tval_w;
                stinst_o <= tinst_w;
                priv_o   <= PRIV_S;
            end else begin
                mepc_o   <= cur_pc_i;
                mtval_o  <= tval_w;
                mtinst_o <= tinst_w;
                priv_o   <= PRIV_M;
            end
        end
    end
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = $clog2(XLEN)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               trap_req_i,
    input logic               trap_is_irq_i,
    input logic [CAUSE_W-1:0] trap_cause_i,
    input logic [XLEN-1:0]    cur_pc_i,
    input logic [1:0]         cur_priv_i,
    input logic [XLEN-1:0]    medeleg_i,
    input logic [XLEN-1:0]    sepc_o,
    input logic [XLEN-1:0]    stval_o,
    input logic [XLEN-1:0]    stinst_o,
    input logic [XLEN-1:0]    mepc_o,
    input logic [XLEN-1:0]    mtval_o,
    input logic [XLEN-1:0]    mtinst_o,
    input logic [XLEN-1:0]    pc_o,
    input logic [1:0]         priv_o,
    input logic               redirect_o
);
    // R11
    redirect_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req_i |=> redirect_o);

    // R11
    no_redirect_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_req_i |=> !redirect_o);

    // R11
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_req_i |=> ($stable(sepc_o) && $stable(mepc_o) && $stable(stval_o) &&
                         $stable(mtval_o) && $stable(stinst_o) && $stable(mtinst_o) &&
                         $stable(pc_o) && $stable(priv_o)));

    // R3
    m_stays_m_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req_i && cur_priv_i == 2'b11) |=> (priv_o == 2'b11 && mepc_o == $past(cur_pc_i)));

    // R9
    target_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req_i |=> (pc_o[1:0] == 2'b00));

    // R8
    irq_info_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req_i && trap_is_irq_i) |=>
            ((priv_o == 2'b01) ? (stval_o == '0 && stinst_o == '0)
                               : (mtval_o == '0 && mtinst_o == '0)));

    // R4
    exc_to_super_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req_i && !trap_is_irq_i && cur_priv_i != 2'b11 && cur_priv_i != 2'b10 &&
         medeleg_i[trap_cause_i]) |=> (priv_o == 2'b01 && sepc_o == $past(cur_pc_i) &&
                                        $stable(mepc_o)));
endmodule

bind trap_entry_ctrl trap_entry_chk #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .trap_req_i    (trap_req_i),
    .trap_is_irq_i (trap_is_irq_i),
    .trap_cause_i  (trap_cause_i),
    .cur_pc_i      (cur_pc_i),
    .cur_priv_i    (cur_priv_i),
    .medeleg_i     (medeleg_i),
    .sepc_o        (sepc_o),
    .stval_o       (stval_o),
    .stinst_o      (stinst_o),
    .mepc_o        (mepc_o),
    .mtval_o       (mtval_o),
    .mtinst_o      (mtinst_o),
    .pc_o          (pc_o),
    .priv_o        (priv_o),
    .redirect_o    (redirect_o)
);

// File: tb/tb_trap_entry_ctrl.sv
`timescale 1ns/1ps
module tb_trap_entry_ctrl;
    localparam int XLEN = 32;
    localparam int CW   = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trap_req = 1'b0, is_irq = 1'b0;
    logic [CW-1:0] cause = '0;
    logic [31:0] cur_pc = '0, faddr = '0, xinst = '0;
    logic [1:0]  cur_priv = 2'b00;
    logic [31:0] mideleg = '0, medeleg = '0, mtvec = '0, stvec = '0;
    logic [31:0] sepc, stval, stinst, mepc, mtval, mtinst, pc;
    logic [1:0]  priv;
    logic        redirect;

    always #10 clk = ~clk; // 50 MHz

    trap_entry_ctrl #(.XLEN(XLEN), .RESET_PC(32'h0000_0000)) dut (
        .clk(clk), .rst_n(rst_n), .trap_req_i(trap_req), .trap_is_irq_i(is_irq),
        .trap_cause_i(cause), .cur_pc_i(cur_pc), .cur_priv_i(cur_priv),
        .fault_addr_i(faddr), .xinst_i(xinst), .mideleg_i(mideleg), .medeleg_i(medeleg),
        .mtvec_i(mtvec), .stvec_i(stvec), .sepc_o(sepc), .stval_o(stval),
        .stinst_o(stinst), .mepc_o(mepc), .mtval_o(mtval), .mtinst_o(mtinst),
        .pc_o(pc), .priv_o(priv), .redirect_o(redirect)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;
    bit model_ok = 1'b0;

    // Behavioural reference state
    logic [31:0] e_sepc, e_stval, e_stinst, e_mepc, e_mtval, e_mtinst, e_pc;
    logic [1:0]  e_priv;
    logic        e_redir;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            e_sepc = 0; e_stval = 0; e_stinst = 0;
            e_mepc = 0; e_mtval = 0; e_mtinst = 0;
            e_pc = 0; e_priv = 2'd3; e_redir = 0;
            model_ok = 1'b1;
        end else if (trap_req) begin
            int c;
            bit to_s;
            logic [31:0] tv, ti, vec;
            c = int'(cause);
            to_s = (cur_priv == 2'd0 || cur_priv == 2'd1) &&
                   (is_irq ? mideleg[c] : medeleg[c]);
            tv = 0; ti = 0;
            if (!is_irq) begin
                if (c inside {4, 5, 6, 7, 13, 15, 21, 23}) begin tv = faddr; ti = xinst; end
                else if (c inside {0, 1, 12, 20}) tv = faddr;
            end
            vec = to_s ? stvec : mtvec;
            e_pc = (vec / 4) * 4;
            if (is_irq && vec % 4 == 1) e_pc = e_pc + 32'(c * 4);
            if (to_s) begin e_sepc = cur_pc; e_stval = tv; e_stinst = ti; e_priv = 2'd1; end
            else      begin e_mepc = cur_pc; e_mtval = tv; e_mtinst = ti; e_priv = 2'd3; end
            e_redir = 1;
        end else begin
            e_redir = 0;
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (model_ok && !done) begin
            chk("R4", "sepc", sepc, e_sepc);
            chk("R6", "stval", stval, e_stval);
            chk("R6", "stinst", stinst, e_stinst);
            chk("R5", "mepc", mepc, e_mepc);
            chk("R7", "mtval", mtval, e_mtval);
            chk("R7", "mtinst", mtinst, e_mtinst);
            chk("R9", "pc", pc, e_pc);
            chk("R2", "priv", {30'd0, priv}, {30'd0, e_priv});
            chk("R11", "redirect", {31'd0, redirect}, {31'd0, e_redir});
        end
    end

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic fire(input logic irq, input int c, input logic [1:0] pv, input logic [31:0] p);
        trap_req = 1'b1; is_irq = irq; cause = CW'(c); cur_priv = pv; cur_pc = p;
        step();
        trap_req = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        step();
        // R1 reset state
        chk("R1", "rst priv", {30'd0, priv}, 32'd3);
        chk("R1", "rst pc", pc, 32'd0);
        chk("R1", "rst mepc", mepc, 32'd0);
        chk("R1", "rst redirect", {31'd0, redirect}, 32'd0);
        rst_n = 1'b1;
        step();

        // R2/R4/R6/R10: U-mode load access fault, delegated, vectored stvec, exception -> no offset
        medeleg = 32'h0000_0020; mideleg = 32'h0000_0004;
        stvec = 32'h8000_1001; mtvec = 32'h2000_0000;
        faddr = 32'h1234_5678; xinst = 32'h0000_a503;
        fire(1'b0, 5, 2'd0, 32'h0000_0040);
        chk("R4", "S sepc", sepc, 32'h40);
        chk("R6", "S stval", stval, 32'h1234_5678);
        chk("R6", "S stinst", stinst, 32'h0000_a503);
        chk("R10", "exc no offset", pc, 32'h8000_1000);
        chk("R2", "deleg to S", {30'd0, priv}, 32'd1);
        chk("R11", "redirect pulse", {31'd0, redirect}, 32'd1);

        // R3: same cause from M stays in M
        fire(1'b0, 5, 2'd3, 32'h0000_0080);
        chk("R3", "M stays", {30'd0, priv}, 32'd3);
        chk("R5", "M mepc", mepc, 32'h80);
        chk("R5", "M mtinst", mtinst, 32'h0000_a503);
        chk("R5", "sepc unchanged", sepc, 32'h40);
        chk("R9", "direct mtvec", pc, 32'h2000_0000);

        // R10/R8: S-mode interrupt 9 delegated, vectored
        mideleg = 32'h0000_0200; medeleg = 32'h0;
        fire(1'b1, 9, 2'd1, 32'h0000_0100);
        chk("R10", "irq offset", pc, 32'h8000_1024);
        chk("R8", "irq stval", stval, 32'h0);
        chk("R8", "irq stinst", stinst, 32'h0);

        // R7: fetch page fault, not delegated
        fire(1'b0, 12, 2'd1, 32'h0000_0200);
        chk("R7", "fetch mtval", mtval, 32'h1234_5678);
        chk("R7", "fetch mtinst", mtinst, 32'h0);
        chk("R2", "medeleg clear -> M", {30'd0, priv}, 32'd3);

        // R2/R8: illegal instruction; mideleg bit 2 set, medeleg bit 2 clear -> M
        mideleg = 32'h0000_0004;
        fire(1'b0, 2, 2'd0, 32'h0000_0300);
        chk("R2", "exception ignores mideleg", {30'd0, priv}, 32'd3);
        chk("R8", "illegal mtval", mtval, 32'h0);
        chk("R8", "illegal mtinst", mtinst, 32'h0);

        // R11: idle cycle with noisy inputs holds everything
        cur_pc = 32'hdead_beef; faddr = 32'hffff_ffff; cause = CW'(5);
        step();
        chk("R11", "idle mepc hold", mepc, 32'h300);
        chk("R11", "idle no redirect", {31'd0, redirect}, 32'd0);

        // R10: M interrupt 7 with vectored mtvec
        mtvec = 32'h2000_0001;
        fire(1'b1, 7, 2'd3, 32'h0000_0400);
        chk("R10", "M irq offset", pc, 32'h2000_001c);

        // Random traffic compared against the model every clock
        for (int i = 0; i < 3000; i++) begin
            int pr;
            trap_req = ($urandom_range(0, 2) != 0);
            is_irq   = $urandom_range(0, 1) == 1;
            cause    = is_irq ? CW'($urandom_range(0, 15)) : CW'($urandom_range(0, 23));
            pr       = $urandom_range(0, 2);
            cur_priv = (pr == 2) ? 2'd3 : 2'(pr);
            cur_pc   = $urandom; faddr = $urandom; xinst = $urandom;
            mideleg  = $urandom; medeleg = $urandom;
            mtvec    = $urandom; stvec = $urandom;
            step();
        end
        trap_req = 1'b0;
        step();
        finish_run();
    end
endmodule